// File: doc/BRIEF.md
# Precomputation-Gated Magnitude Comparator

This block compares two unsigned operands, A and B, and reports whether A is greater than B. Both operands are captured in registers before the compare. The capture is split in two. The top bit of each operand goes into a small bank that loads on every clock. The lower bits of both operands go into a second bank, and that bank loads only when the two top bits are equal.

When the top bits differ, they already settle the answer: A is greater exactly when its top bit is 1. In that case the lower-bit bank keeps its previous contents and does not toggle. Its flops and the lower part of the compare logic stay quiet for that cycle. The enable is worked out from the incoming top bits alone. It never looks at the gated bank.

A parameter selects where the result is taken from. In one variant it comes from a result register, one cycle after the operand registers. In the other it is driven combinationally from the operand registers. The lower-bank load enable is brought out as a port, so activity can be observed. The external active-low reset clears everything at once. Its release passes through a two-stage synchronizer.

Top module: `msb_gated_comparator`

## Requirements
- R1: While reset is asserted, every register is cleared and `a_gt_b` reads 0, without waiting for a clock edge.
- R2: The top-bit bank captures the top bits of `a_in` and `b_in` at every rising edge once reset is released.
- R3: `low_load_en` is 1 exactly when `a_in[WIDTH-1]` equals `b_in[WIDTH-1]`. When it is 1, the lower bank captures `a_in[WIDTH-2:0]` and `b_in[WIDTH-2:0]` at that edge.
- R4: When `low_load_en` is 0, the lower bank keeps its contents. The lower input bits then have no effect on `a_gt_b`.
- R5: When the captured top bits differ, the result equals the captured top bit of A.
- R6: When the captured top bits are equal, the result is the unsigned compare of the lower bits. Equal operands give 0.
- R7: The operands present at rising edge k give their result after edge k+1 when `OUT_REG`=1, and after edge k when `OUT_REG`=0.
- R8: For any input sequence, including alternating gated and loading cycles, `a_gt_b` equals the ungated unsigned compare `A > B` of the same operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both operand banks and the result register |
| rst_n | input | 1 | Active-low reset; asserts at once, release is synchronized |
| a_in | input | WIDTH | Operand A, unsigned |
| b_in | input | WIDTH | Operand B, unsigned |
| a_gt_b | output | 1 | 1 when the captured A is greater than the captured B |
| low_load_en | output | 1 | Load enable of the lower-bit bank, for observing gating |

## Verification
The delicate cycle is the one where the lower bank is frozen for a new operand pair. In that same cycle the result register is still settling the previous pair from the lower bits it loaded just before. Dense random streams provoke this overlap: they swap between equal and unequal top bits on every clock. Directed pairs with extreme lower bits then show that those bits are ignored while frozen and picked up again afterwards. Every result is judged against a plain `A > B` computed in the bench for the operands driven one or two cycles earlier. Both output variants run side by side on the same stimulus.

// File: rtl/gcmp_pkg.sv
package gcmp_pkg;

  typedef struct packed {
    logic a;
    logic b;
  } msb_pair_t;

  // 1 when the top bits alone settle the comparison
  function automatic logic msbs_settle(msb_pair_t p);
    return p.a ^ p.b;
  endfunction

endpackage

// File: rtl/gcmp_rst_sync.sv
module gcmp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_nxt;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gcmp_msb_bank.sv
module gcmp_msb_bank
  import gcmp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  msb_pair_t msb_d,
  output msb_pair_t msb_q
);

  msb_pair_t msb_nxt;

  always_comb begin
    msb_nxt = msb_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msb_q <= '0;
    else        msb_q <= msb_nxt;
  end

  // R2: captures the top bits on every edge
  a_r2_msb_every_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> msb_q == $past(msb_d));

endmodule

// File: rtl/gcmp_low_bank.sv
module gcmp_low_bank #(
  parameter int LW = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic [1:0][LW-1:0]  low_d,
  output logic [1:0][LW-1:0]  low_q
);

  logic [1:0][LW-1:0] low_nxt;

  for (genvar op = 0; op < 2; op++) begin : g_operand
    always_comb begin
      low_nxt[op] = load_en ? low_d[op] : low_q[op];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) low_q[op] <= '0;
      else        low_q[op] <= low_nxt[op];
    end
  end

  // R4: gated bank holds while disabled
  a_r4_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(low_q));

  // R3: enabled bank captures the lower bits
  a_r3_low_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> low_q == $past(low_d));

endmodule

// File: rtl/gcmp_decide.sv
module gcmp_decide
  import gcmp_pkg::*;
#(
  parameter int LW      = 15,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  msb_pair_t     msb_q,
  input  logic [LW-1:0] a_low_q,
  input  logic [LW-1:0] b_low_q,
  output logic          gt
);

  logic gt_c;
  logic low_gt;

  always_comb begin
    low_gt = (a_low_q > b_low_q);
    gt_c   = msbs_settle(msb_q) ? msb_q.a : low_gt;
  end

  if (OUT_REG) begin : g_reg_out
    logic gt_q;
    logic gt_nxt;

    always_comb begin
      gt_nxt = gt_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gt_q <= 1'b0;
      else        gt_q <= gt_nxt;
    end

    assign gt = gt_q;

    // R5: differing top bits decide the registered result
    a_r5_msb_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      (msb_q.a != msb_q.b) |=> gt == $past(msb_q.a));

    // R6: equal operands never report greater
    a_r6_equal_not_gt: assert property (@(posedge clk) disable iff (!rst_n)
      (msb_q.a == msb_q.b && a_low_q == b_low_q) |=> !gt);
  end else begin : g_comb_out
    assign gt = gt_c;

    // R5: differing top bits decide the result
    a_r5_msb_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      (msb_q.a != msb_q.b) |-> gt == msb_q.a);

    // R6: equal operands never report greater
    a_r6_equal_not_gt: assert property (@(posedge clk) disable iff (!rst_n)
      (msb_q.a == msb_q.b && a_low_q == b_low_q) |-> !gt);
  end

endmodule

// File: rtl/msb_gated_comparator.sv
module msb_gated_comparator
  import gcmp_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic             a_gt_b,
  output logic             low_load_en
);

  localparam int LW = WIDTH - 1;

  logic               rst_n_sync;
  msb_pair_t          msb_in;
  msb_pair_t          msb_q;
  logic [1:0][LW-1:0] low_in;
  logic [1:0][LW-1:0] low_q;
  logic               load_en;

  always_comb begin
    msb_in.a  = a_in[WIDTH-1];
    msb_in.b  = b_in[WIDTH-1];
    low_in[0] = a_in[LW-1:0];
    low_in[1] = b_in[LW-1:0];
    load_en   = ~msbs_settle(msb_in);
  end

  assign low_load_en = load_en;

  gcmp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_n_sync)
  );

  gcmp_msb_bank u_msb_bank (
    .clk  (clk),
    .rst_n(rst_n_sync),
    .msb_d(msb_in),
    .msb_q(msb_q)
  );

  gcmp_low_bank #(.LW(LW)) u_low_bank (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .load_en(load_en),
    .low_d  (low_in),
    .low_q  (low_q)
  );

  gcmp_decide #(.LW(LW), .OUT_REG(OUT_REG)) u_decide (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .msb_q  (msb_q),
    .a_low_q(low_q[0]),
    .b_low_q(low_q[1]),
    .gt     (a_gt_b)
  );

endmodule

// File: tb/msb_gated_comparator_tb_top.sv
module msb_gated_comparator_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in;
  logic [W-1:0] b_in;
  logic         gt_reg, gt_cmb, en_reg, en_cmb;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msb_gated_comparator #(.WIDTH(W), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .a_gt_b(gt_reg), .low_load_en(en_reg));

  msb_gated_comparator #(.WIDTH(W), .OUT_REG(1'b0)) dut_comb_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .a_gt_b(gt_cmb), .low_load_en(en_cmb));

  task automatic check(string req, logic act, logic exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: actual %b expected %b (a=%h b=%h)", req, act, exp, a_in, b_in);
    end
  endtask

  // Apply one pair and follow it through both output variants
  task automatic one_pair(logic [W-1:0] a, logic [W-1:0] b, string req);
    @(negedge clk);
    a_in = a; b_in = b;
    #1;
    check({req, " R3 enable"}, en_reg, a[W-1] == b[W-1]);
    @(negedge clk);
    check({req, " R7 comb"}, gt_cmb, a > b);
    @(negedge clk);
    check({req, " R7 reg"}, gt_reg, a > b);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    check("R1 reg out in reset", gt_reg, 1'b0);
    check("R1 comb out in reset", gt_cmb, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reg out after release", gt_reg, 1'b0);
  endtask

  task automatic t_msb_differ();
    one_pair(16'h8000, 16'h7FFF, "R5 A top set");
    one_pair(16'h7FFF, 16'h8000, "R5 B top set");
    one_pair(16'h8000, 16'h0000, "R2 top bit only");
  endtask

  task automatic t_msb_equal();
    one_pair(16'h0124, 16'h0123, "R6 low greater");
    one_pair(16'h0123, 16'h0124, "R6 low smaller");
    one_pair(16'hABCD, 16'hABCD, "R6 equal operands");
    one_pair(16'hFFFF, 16'hFFFE, "R6 high half");
    one_pair(16'h0000, 16'h0000, "R6 zeros");
  endtask

  // Load small low bits, then freeze with extreme low inputs, then reload
  task automatic t_frozen();
    one_pair(16'h0001, 16'h0002, "R4 preload");
    one_pair(16'h8000, 16'h7FFF, "R4 frozen lows ignored A");
    one_pair(16'h7FFF, 16'hFFFF, "R4 frozen lows ignored B");
    @(negedge clk); #1;
    check("R4 enable low while differing", en_reg, 1'b0);
    one_pair(16'h0456, 16'h0123, "R4 reload after freeze");
  endtask

  // Back-to-back stream, scoreboard with one and two cycle history
  task automatic t_stream();
    logic h1v = 1'b0, h2v = 1'b0, h1 = 1'b0, h2 = 1'b0;
    int gated = 0;
    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] a, b;
      @(negedge clk);
      if (h1v) check("R8 stream comb", gt_cmb, h1);
      if (h2v) check("R8 stream reg", gt_reg, h2);
      a = W'($urandom);
      b = W'($urandom);
      if (i % 3 == 0) b[W-1] = a[W-1];
      if (i % 7 == 0) b = a;
      a_in = a; b_in = b;
      #1;
      if (!en_reg) gated++;
      if (en_reg !== en_cmb) check("R3 enables agree", en_reg, en_cmb);
      h2 = h1; h2v = h1v;
      h1 = (a > b); h1v = 1'b1;
    end
    tests_run++;
    if (gated == 0 || gated == 600) begin
      tests_failed++;
      $display("FAIL R3 gated cycle count: actual %0d expected between 1 and 599", gated);
    end
  endtask

  task automatic t_reset_mid();
    one_pair(16'hFFFF, 16'h0000, "R1 before reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async clear reg", gt_reg, 1'b0);
    check("R1 async clear comb", gt_cmb, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_msb_differ();
    t_msb_equal();
    t_frozen();
    t_stream();
    t_reset_mid();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule